// File: doc/BRIEF.md
# Event-Triggered Programmable Timer Channel

This block is one timer channel of a flexible serial-emulation engine. It counts down from a programmed compare value, toggles a timer output as it counts, and offers a shift clock that a neighbouring shift register can use. Software programs it through a small two-word write port: a control word holding the encoded modes and conditions, and a compare word holding the reload value.

The channel decides when to begin counting, when to stop and when to reload. It makes those decisions from an encoded set of conditions built on the trigger level and edges, the pin edges, and the enable and disable pulses of the previous channel in a chain. It can run as one 16-bit counter, as two 8-bit halves that produce a bit clock and a bit count, or as two 8-bit halves that set the high and low times of a PWM waveform. Optional start and stop periods can be inserted around the counting phase. A sticky status flag records each compare event. The channel also emits one-cycle enable and disable pulses so that the next channel in a chain can follow it.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, the timer output, status flag, enable pulse and disable pulse are all 0 and the channel is idle.
- R2: A write with `cfg_sel_i`=0 loads the control word, and a write with `cfg_sel_i`=1 loads the compare word. The control word fields are: [1:0] mode (0 off, 1 baud/bit, 2 PWM, 3 wide 16-bit), [3:2] initial output, [5:4] decrement source, [8:6] reset condition, [11:9] disable condition, [14:12] enable condition, [16:15] stop period, [17] start period, [18] trigger polarity, [19] trigger source. With mode 0 the channel stays idle and raises no enable pulse and no compare.
- R3: While idle, the channel starts when its enable condition holds: 0 always, 1 previous-channel enable pulse, 2 trigger high, 3 trigger and pin high, 4 pin rising edge, 5 pin rising edge with trigger high, 6 trigger rising edge, 7 either trigger edge. On start it loads the compare value, sets the output high for initial-output codes 0 and 2 and low for codes 1 and 3, and pulses `en_evt_o` for one cycle.
- R4: In wide mode the counter steps down once per tick. A tick with the counter at 0 is a compare event: the output toggles and the counter reloads, so the output toggles every compare+1 ticks.
- R5: In baud/bit mode the low half steps down per tick. When it is 0 it reloads and the output toggles, and the high half steps down. A compare event occurs when both halves are 0 on one tick, that is after (low+1)×(high+1) ticks.
- R6: In PWM mode the output is high for low-half+1 ticks, then low for high-half+1 ticks, and repeats. The compare event comes at the end of the low-output phase.
- R7: Decrement source 0 ticks every clock, 1 ticks on either trigger edge, 2 on either pin edge, 3 on either trigger edge. The shift clock is the timer output for sources 0 and 1, the pin for 2, and the trigger for 3.
- R8: While counting, the reset condition (2 pin equals output, 3 trigger equals output, 4 pin rising, 6 trigger rising, 7 trigger either edge; 0, 1 and 5 never) reloads the counter instead of ticking. For initial-output codes 2 and 3 it also restores the start-up output level.
- R9: While counting, the disable condition (1 previous-channel disable pulse, 2 compare event, 3 compare event with trigger low, 4 either pin edge, 5 either pin edge with trigger high, 6 trigger falling edge; 0 and 7 never) returns the channel to idle and pulses `dis_evt_o` for one cycle.
- R10: With the start bit set, a start period of one reload length (compare+1 ticks in wide mode, low-half+1 ticks otherwise) precedes counting, and the output holds during it.
- R11: Stop-period code bit 0 inserts a held-output stop period after each compare event. Bit 1 inserts one after a disable, and the channel goes idle at its end. The stop period has the same length as a start period.
- R12: The status flag sets on each compare event and clears on a cycle with `flag_clr_i` high. When both happen in the same cycle, the set wins.
- R13: The trigger is `trig_ext_i` when the source bit is 0 and `trig_int_i` when it is 1. It is inverted when the polarity bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Write strobe for the configuration port |
| cfg_sel_i | input | 1 | Write target: 0 control word, 1 compare word |
| cfg_data_i | input | 20 | Write data |
| trig_ext_i | input | 1 | External trigger input |
| trig_int_i | input | 1 | Internal trigger input |
| pin_i | input | 1 | Pin input |
| prev_en_i | input | 1 | Enable pulse from the previous channel |
| prev_dis_i | input | 1 | Disable pulse from the previous channel |
| flag_clr_i | input | 1 | Clears the status flag |
| tmr_out_o | output | 1 | Timer output |
| shift_clk_o | output | 1 | Shift clock for a neighbouring shifter |
| flag_o | output | 1 | Sticky compare status flag |
| en_evt_o | output | 1 | One-cycle pulse when the channel starts |
| dis_evt_o | output | 1 | One-cycle pulse when the channel returns to idle |

## Verification
The assertions assume that the trigger and pin inputs are synchronous to `clk`. They also assume that the chaining pulses last one cycle and that the configuration changes only through the write port. The bench drives every input at the falling clock edge and holds each chain pulse for exactly one cycle. Before each scenario it writes the control word to zero, so that no count left over from an earlier scenario reaches the next one. It keeps the trigger low across reset so that no edge is seen on the first sample.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        TM_OFF  = 2'd0,
        TM_BAUD = 2'd1,
        TM_PWM  = 2'd2,
        TM_WIDE = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_RUN   = 2'd2,
        PH_STOP  = 2'd3
    } phase_e;

    // Control word, most significant field first.
    typedef struct packed {
        logic       trig_src;   // [19]
        logic       trig_pol;   // [18]
        logic       start_en;   // [17]
        logic [1:0] stop_sel;   // [16:15]
        logic [2:0] en_sel;     // [14:12]
        logic [2:0] dis_sel;    // [11:9]
        logic [2:0] rst_sel;    // [8:6]
        logic [1:0] dec_src;    // [5:4]
        logic [1:0] init_out;   // [3:2]
        tmode_e     tmode;      // [1:0]
    } ctl_t;

    localparam int CTL_BITS = $bits(ctl_t);

    function automatic logic start_level(input logic [1:0] init_code);
        return ~init_code[0];
    endfunction

    function automatic logic restores_on_reload(input logic [1:0] init_code);
        return init_code[1];
    endfunction

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [WORD_W-1:0] data_i,
    output ctl_t              ctl_o,
    output logic [CNT_W-1:0]  cmp_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o <= '0;
            cmp_o <= '0;
        end else if (wr_i) begin
            if (sel_i) cmp_o <= data_i[CNT_W-1:0];
            else       ctl_o <= ctl_t'(data_i[CTL_BITS-1:0]);
        end
    end
endmodule

// File: rtl/evt_timer_cond.sv
module evt_timer_cond (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_src_i,
    input  logic       trig_pol_i,
    input  logic [1:0] dec_src_i,
    input  logic [2:0] rst_sel_i,
    input  logic [2:0] dis_sel_i,
    input  logic [2:0] en_sel_i,
    input  logic       trig_ext_i,
    input  logic       trig_int_i,
    input  logic       pin_i,
    input  logic       prev_en_i,
    input  logic       prev_dis_i,
    input  logic       tmr_out_i,
    output logic       en_hit_o,
    output logic       dis_hit_o,
    output logic       dis_on_cmp_o,
    output logic       rld_hit_o,
    output logic       tick_o,
    output logic       shift_clk_o
);
    logic trig, trig_q, pin_q;
    logic trig_rise, trig_fall, trig_any, pin_rise, pin_any;

    assign trig = (trig_src_i ? trig_int_i : trig_ext_i) ^ trig_pol_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            trig_q <= trig;
            pin_q  <= pin_i;
        end
    end

    assign trig_rise = trig & ~trig_q;
    assign trig_fall = ~trig & trig_q;
    assign trig_any  = trig ^ trig_q;
    assign pin_rise  = pin_i & ~pin_q;
    assign pin_any   = pin_i ^ pin_q;

    always_comb begin
        case (en_sel_i)
            3'd0:    en_hit_o = 1'b1;
            3'd1:    en_hit_o = prev_en_i;
            3'd2:    en_hit_o = trig;
            3'd3:    en_hit_o = trig & pin_i;
            3'd4:    en_hit_o = pin_rise;
            3'd5:    en_hit_o = pin_rise & trig;
            3'd6:    en_hit_o = trig_rise;
            default: en_hit_o = trig_any;
        endcase
        case (dis_sel_i)
            3'd1:    dis_hit_o = prev_dis_i;
            3'd4:    dis_hit_o = pin_any;
            3'd5:    dis_hit_o = pin_any & trig;
            3'd6:    dis_hit_o = trig_fall;
            default: dis_hit_o = 1'b0;
        endcase
        dis_on_cmp_o = (dis_sel_i == 3'd2) | ((dis_sel_i == 3'd3) & ~trig);
        case (rst_sel_i)
            3'd2:    rld_hit_o = (pin_i == tmr_out_i);
            3'd3:    rld_hit_o = (trig == tmr_out_i);
            3'd4:    rld_hit_o = pin_rise;
            3'd6:    rld_hit_o = trig_rise;
            3'd7:    rld_hit_o = trig_any;
            default: rld_hit_o = 1'b0;
        endcase
        case (dec_src_i)
            2'd0:    tick_o = 1'b1;
            2'd2:    tick_o = pin_any;
            default: tick_o = trig_any;
        endcase
        case (dec_src_i)
            2'd2:    shift_clk_o = pin_i;
            2'd3:    shift_clk_o = trig;
            default: shift_clk_o = tmr_out_i;
        endcase
    end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmode_e           tmode_i,
    input  logic [1:0]       init_out_i,
    input  logic [1:0]       stop_sel_i,
    input  logic             start_en_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             en_hit_i,
    input  logic             dis_hit_i,
    input  logic             dis_on_cmp_i,
    input  logic             rld_hit_i,
    input  logic             tick_i,
    input  logic             flag_clr_i,
    output logic             tmr_out_o,
    output logic             flag_o,
    output logic             en_evt_o,
    output logic             dis_evt_o
);
    localparam int HALF = CNT_W / 2;

    phase_e           phase_q, phase_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, step_cnt, per_cnt;
    logic             out_q, out_n, to_idle_q, to_idle_n;
    logic             step_tgl, step_wrap, per_end, cmp_evt, go_en, go_dis, stopping;
    logic [HALF-1:0]  lo, hi, cmp_lo, cmp_hi;

    assign lo     = cnt_q[HALF-1:0];
    assign hi     = cnt_q[CNT_W-1:HALF];
    assign cmp_lo = cmp_i[HALF-1:0];
    assign cmp_hi = cmp_i[CNT_W-1:HALF];

    // One counting step in the selected mode.
    always_comb begin
        step_cnt  = cnt_q;
        step_tgl  = 1'b0;
        step_wrap = 1'b0;
        case (tmode_i)
            TM_WIDE: begin
                if (cnt_q == '0) begin
                    step_cnt  = cmp_i;
                    step_tgl  = 1'b1;
                    step_wrap = 1'b1;
                end else begin
                    step_cnt = cnt_q - 1'b1;
                end
            end
            TM_BAUD: begin
                if (lo == '0) begin
                    step_tgl = 1'b1;
                    if (hi == '0) begin
                        step_wrap = 1'b1;
                        step_cnt  = cmp_i;
                    end else begin
                        step_cnt = {hi - 1'b1, cmp_lo};
                    end
                end else begin
                    step_cnt = {hi, lo - 1'b1};
                end
            end
            TM_PWM: begin
                if (out_q) begin
                    if (lo == '0) begin
                        step_tgl = 1'b1;
                        step_cnt = {hi, cmp_lo};
                    end else begin
                        step_cnt = {hi, lo - 1'b1};
                    end
                end else begin
                    if (hi == '0) begin
                        step_tgl  = 1'b1;
                        step_wrap = 1'b1;
                        step_cnt  = {cmp_hi, lo};
                    end else begin
                        step_cnt = {hi - 1'b1, lo};
                    end
                end
            end
            default: ;
        endcase
    end

    // Start and stop periods share the counter.
    assign per_end = (tmode_i == TM_WIDE) ? (cnt_q == '0) : (lo == '0);
    assign per_cnt = (tmode_i == TM_WIDE) ? (cnt_q - 1'b1) : {hi, lo - 1'b1};

    always_comb begin
        phase_n   = phase_q;
        cnt_n     = cnt_q;
        out_n     = out_q;
        to_idle_n = to_idle_q;
        cmp_evt   = 1'b0;
        go_en     = 1'b0;
        go_dis    = 1'b0;
        stopping  = 1'b0;
        if (tmode_i == TM_OFF) begin
            phase_n = PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (en_hit_i) begin
                        phase_n = start_en_i ? PH_START : PH_RUN;
                        cnt_n   = cmp_i;
                        out_n   = start_level(init_out_i);
                        go_en   = 1'b1;
                    end
                end
                PH_START: begin
                    if (tick_i) begin
                        if (per_end) begin
                            phase_n = PH_RUN;
                            cnt_n   = cmp_i;
                        end else begin
                            cnt_n = per_cnt;
                        end
                    end
                end
                PH_RUN: begin
                    if (rld_hit_i) begin
                        cnt_n = cmp_i;
                        if (restores_on_reload(init_out_i)) out_n = start_level(init_out_i);
                    end else if (tick_i) begin
                        cnt_n   = step_cnt;
                        out_n   = out_q ^ step_tgl;
                        cmp_evt = step_wrap;
                    end
                    if (dis_hit_i || (cmp_evt && dis_on_cmp_i)) begin
                        if (stop_sel_i[1]) begin
                            stopping  = 1'b1;
                            to_idle_n = 1'b1;
                        end else begin
                            phase_n = PH_IDLE;
                            go_dis  = 1'b1;
                        end
                    end else if (cmp_evt && stop_sel_i[0]) begin
                        stopping  = 1'b1;
                        to_idle_n = 1'b0;
                    end
                    if (stopping) begin
                        phase_n = PH_STOP;
                        cnt_n   = cmp_i;
                    end
                end
                default: begin
                    if (tick_i) begin
                        if (per_end) begin
                            if (to_idle_q) begin
                                phase_n = PH_IDLE;
                                go_dis  = 1'b1;
                            end else begin
                                phase_n = PH_RUN;
                                cnt_n   = cmp_i;
                            end
                        end else begin
                            cnt_n = per_cnt;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            out_q     <= 1'b0;
            to_idle_q <= 1'b0;
            flag_o    <= 1'b0;
            en_evt_o  <= 1'b0;
            dis_evt_o <= 1'b0;
        end else begin
            phase_q   <= phase_n;
            cnt_q     <= cnt_n;
            out_q     <= out_n;
            to_idle_q <= to_idle_n;
            en_evt_o  <= go_en;
            dis_evt_o <= go_dis;
            if (cmp_evt)         flag_o <= 1'b1;
            else if (flag_clr_i) flag_o <= 1'b0;
        end
    end

    assign tmr_out_o = out_q;

    a_r2_off_goes_idle: assert property (@(posedge clk) disable iff (rst)
        (tmode_i == TM_OFF) |=> (phase_q == PH_IDLE));
    a_r3_en_pulse_running: assert property (@(posedge clk) disable iff (rst)
        en_evt_o |-> (phase_q != PH_IDLE));
    a_r9_dis_pulse_idle: assert property (@(posedge clk) disable iff (rst)
        dis_evt_o |-> (phase_q == PH_IDLE));
    a_r12_flag_follows_cmp: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |=> flag_o);
    a_r12_no_cmp_when_idle: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> !cmp_evt);
    a_r10_start_holds_out: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_START) |=> $stable(out_q));
    a_r11_stop_holds_out: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STOP) |=> $stable(out_q));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter  int CNT_W  = 16,
    localparam int WORD_W = (CTL_BITS > CNT_W) ? CTL_BITS : CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_i,
    input  logic              cfg_sel_i,
    input  logic [WORD_W-1:0] cfg_data_i,
    input  logic              trig_ext_i,
    input  logic              trig_int_i,
    input  logic              pin_i,
    input  logic              prev_en_i,
    input  logic              prev_dis_i,
    input  logic              flag_clr_i,
    output logic              tmr_out_o,
    output logic              shift_clk_o,
    output logic              flag_o,
    output logic              en_evt_o,
    output logic              dis_evt_o
);
    ctl_t             ctl;
    logic [CNT_W-1:0] cmp;
    logic             en_hit, dis_hit, dis_on_cmp, rld_hit, tick;

    evt_timer_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst(rst), .wr_i(cfg_wr_i), .sel_i(cfg_sel_i),
        .data_i(cfg_data_i), .ctl_o(ctl), .cmp_o(cmp)
    );

    evt_timer_cond u_cond (
        .clk(clk), .rst(rst),
        .trig_src_i(ctl.trig_src), .trig_pol_i(ctl.trig_pol),
        .dec_src_i(ctl.dec_src), .rst_sel_i(ctl.rst_sel),
        .dis_sel_i(ctl.dis_sel), .en_sel_i(ctl.en_sel),
        .trig_ext_i(trig_ext_i), .trig_int_i(trig_int_i), .pin_i(pin_i),
        .prev_en_i(prev_en_i), .prev_dis_i(prev_dis_i), .tmr_out_i(tmr_out_o),
        .en_hit_o(en_hit), .dis_hit_o(dis_hit), .dis_on_cmp_o(dis_on_cmp),
        .rld_hit_o(rld_hit), .tick_o(tick), .shift_clk_o(shift_clk_o)
    );

    evt_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst),
        .tmode_i(ctl.tmode), .init_out_i(ctl.init_out),
        .stop_sel_i(ctl.stop_sel), .start_en_i(ctl.start_en), .cmp_i(cmp),
        .en_hit_i(en_hit), .dis_hit_i(dis_hit), .dis_on_cmp_i(dis_on_cmp),
        .rld_hit_i(rld_hit), .tick_i(tick), .flag_clr_i(flag_clr_i),
        .tmr_out_o(tmr_out_o), .flag_o(flag_o),
        .en_evt_o(en_evt_o), .dis_evt_o(dis_evt_o)
    );
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, cfg_wr, cfg_sel;
    logic [19:0] cfg_data;
    logic        trig_ext, trig_int, pin, prev_en, prev_dis, flag_clr;
    logic        tmr_out, shift_clk, flag, en_evt, dis_evt;
    int          checks = 0;
    int          failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evt_timer uut (
        .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_data_i(cfg_data), .trig_ext_i(trig_ext), .trig_int_i(trig_int),
        .pin_i(pin), .prev_en_i(prev_en), .prev_dis_i(prev_dis),
        .flag_clr_i(flag_clr), .tmr_out_o(tmr_out), .shift_clk_o(shift_clk),
        .flag_o(flag), .en_evt_o(en_evt), .dis_evt_o(dis_evt)
    );

    function automatic logic [19:0] word(input int mode, input int init, input int dec,
                                         input int rsel, input int dsel, input int esel,
                                         input int stop, input int start, input int pol,
                                         input int src);
        logic [19:0] w;
        w        = '0;
        w[1:0]   = 2'(mode);
        w[3:2]   = 2'(init);
        w[5:4]   = 2'(dec);
        w[8:6]   = 3'(rsel);
        w[11:9]  = 3'(dsel);
        w[14:12] = 3'(esel);
        w[16:15] = 2'(stop);
        w[17]    = 1'(start);
        w[18]    = 1'(pol);
        w[19]    = 1'(src);
        return w;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Turn the channel off, then load compare and control; the channel may
    // start on the first rising edge after this returns.
    task automatic configure(input logic [15:0] cmp, input logic [19:0] w);
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = '0;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_data = {4'd0, cmp};
        @(negedge clk);
        cfg_sel = 1'b0; cfg_data = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "out", tmr_out, 1'b0);
        check("R1", "flag", flag, 1'b0);
        check("R1", "en_evt", en_evt, 1'b0);
        check("R1", "dis_evt", dis_evt, 1'b0);
        check("R1", "shift_clk", shift_clk, 1'b0);
    endtask

    task automatic t_wide_and_flag();
        configure(16'd3, word(3, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        step(1);
        check("R3", "en pulse", en_evt, 1'b1);
        check("R3", "initial high", tmr_out, 1'b1);
        step(3);
        check("R4", "before compare", tmr_out, 1'b1);
        step(1);
        check("R4", "toggle at compare", tmr_out, 1'b0);
        check("R12", "flag set", flag, 1'b1);
        flag_clr = 1'b1;
        step(1);
        check("R12", "flag cleared", flag, 1'b0);
        step(3);
        check("R12", "set wins over clear", flag, 1'b1);
        check("R4", "second toggle", tmr_out, 1'b1);
        flag_clr = 1'b0;
    endtask

    task automatic t_baud();
        trig_ext = 1'b1;
        configure({8'd3, 8'd1}, word(1, 1, 0, 0, 2, 2, 0, 0, 0, 0));
        step(1);
        trig_ext = 1'b0;
        check("R3", "trigger-high enable", en_evt, 1'b1);
        check("R3", "initial low", tmr_out, 1'b0);
        step(2);
        check("R5", "bit toggle", tmr_out, 1'b1);
        step(5);
        check("R5", "no compare yet", dis_evt, 1'b0);
        step(1);
        check("R9", "disable on compare", dis_evt, 1'b1);
        check("R5", "out after frame", tmr_out, 1'b0);
        step(2);
        check("R9", "stays idle", en_evt, 1'b0);
        check("R9", "out held idle", tmr_out, 1'b0);
    endtask

    task automatic t_pwm();
        configure({8'd2, 8'd1}, word(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        step(2);
        check("R6", "high phase", tmr_out, 1'b1);
        step(1);
        check("R6", "low phase begins", tmr_out, 1'b0);
        step(2);
        check("R6", "low phase holds", tmr_out, 1'b0);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        check("R6", "high again", tmr_out, 1'b1);
        check("R6", "compare at end of low", flag, 1'b1);
    endtask

    task automatic t_pin_tick();
        configure(16'd1, word(3, 0, 2, 0, 0, 0, 0, 0, 0, 0));
        step(4);
        check("R7", "no tick without pin edges", tmr_out, 1'b1);
        pin = 1'b1;
        #1 check("R7", "shift clock follows pin", shift_clk, 1'b1);
        step(1);
        check("R7", "one pin edge", tmr_out, 1'b1);
        pin = 1'b0;
        step(1);
        check("R7", "second pin edge compares", tmr_out, 1'b0);
        configure(16'd9, word(3, 0, 3, 0, 0, 0, 0, 0, 0, 0));
        trig_ext = 1'b1;
        #1 check("R7", "shift clock follows trigger", shift_clk, 1'b1);
        step(1);
        trig_ext = 1'b0;
        step(1);
    endtask

    task automatic t_reload();
        configure(16'd3, word(3, 2, 0, 6, 0, 0, 0, 0, 0, 0));
        step(5);
        check("R8", "first compare", tmr_out, 1'b0);
        trig_ext = 1'b1;
        step(1);
        check("R8", "reload restores level", tmr_out, 1'b1);
        step(3);
        check("R8", "count restarted", tmr_out, 1'b1);
        step(1);
        check("R8", "compare after reload", tmr_out, 1'b0);
        trig_ext = 1'b0;
        step(1);
    endtask

    task automatic t_chain();
        configure(16'd100, word(3, 1, 0, 0, 1, 1, 0, 0, 0, 0));
        step(2);
        check("R3", "waits for previous enable", en_evt, 1'b0);
        prev_en = 1'b1;
        step(1);
        prev_en = 1'b0;
        check("R3", "previous enable starts", en_evt, 1'b1);
        step(3);
        prev_dis = 1'b1;
        step(1);
        prev_dis = 1'b0;
        check("R9", "previous disable stops", dis_evt, 1'b1);
        step(1);
        check("R9", "disable pulse one cycle", dis_evt, 1'b0);
    endtask

    task automatic t_trig_edges();
        configure(16'd200, word(3, 0, 0, 0, 6, 6, 0, 0, 0, 0));
        step(2);
        check("R3", "no rising edge yet", en_evt, 1'b0);
        trig_ext = 1'b1;
        step(1);
        check("R3", "rising edge starts", en_evt, 1'b1);
        step(2);
        trig_ext = 1'b0;
        step(1);
        check("R9", "falling edge stops", dis_evt, 1'b1);
    endtask

    task automatic t_trig_select();
        configure(16'd200, word(3, 0, 0, 0, 0, 2, 0, 0, 1, 0));
        step(1);
        check("R13", "inverted low trigger enables", en_evt, 1'b1);
        configure(16'd200, word(3, 0, 0, 0, 0, 2, 0, 0, 0, 1));
        step(1);
        check("R13", "external ignored when internal selected", en_evt, 1'b0);
        trig_int = 1'b1;
        step(1);
        check("R13", "internal trigger enables", en_evt, 1'b1);
        trig_int = 1'b0;
    endtask

    task automatic t_start_bit();
        configure(16'd2, word(3, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        step(6);
        check("R10", "held through start period", tmr_out, 1'b1);
        step(1);
        check("R10", "compare after start period", tmr_out, 1'b0);
    endtask

    task automatic t_stop_bits();
        configure(16'd1, word(3, 0, 0, 0, 0, 0, 1, 0, 0, 0));
        step(3);
        check("R11", "compare before stop", tmr_out, 1'b0);
        step(2);
        check("R11", "held through stop period", tmr_out, 1'b0);
        step(2);
        check("R11", "next compare after stop", tmr_out, 1'b1);
        trig_ext = 1'b1;
        configure(16'd1, word(3, 0, 0, 0, 2, 2, 2, 0, 0, 0));
        step(1);
        trig_ext = 1'b0;
        step(2);
        check("R11", "no disable pulse during stop", dis_evt, 1'b0);
        step(2);
        check("R11", "idle after stop on disable", dis_evt, 1'b1);
    endtask

    task automatic t_mode_off();
        configure(16'd0, word(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        step(5);
        check("R2", "mode off: no enable", en_evt, 1'b0);
        check("R2", "mode off: no compare", flag, 1'b0);
        check("R2", "mode off: output held", tmr_out, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_data = '0;
        trig_ext = 1'b0; trig_int = 1'b0; pin = 1'b0;
        prev_en = 1'b0; prev_dis = 1'b0; flag_clr = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_wide_and_flag();
        t_baud();
        t_pwm();
        t_pin_tick();
        t_reload();
        t_chain();
        t_trig_edges();
        t_trig_select();
        t_start_bit();
        t_stop_bits();
        t_mode_off();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule